// File: doc/BRIEF.md
# Reset-Phase Registered Bypass Transceiver

While the chip-level reset input is held low, this block carries 36-bit words between a master side (port A) and a slave side (port B). It does not use the queue storage. Each transfer passes through one register stage. Port A alone decides whether a transfer happens and which way it goes: its read/write control selects the direction, and reset does not override that control. A write carries the port A input to the port B output. A read carries the port B input to the port A output. The port B controls have no say while the bypass is active.

The block also qualifies reset. Reset counts as complete only once the clock has both risen and fallen while reset was low. When reset returns high, both bypass outputs go idle. If the qualification was met, a reset-done indication rises and stays high. A master processor can use the path to push configuration words into a peripheral, or pull them back, before normal traffic begins.

Top module: `rbx_top`

## Requirements
- R1: With reset low and port A enable and request both high at a rising clock edge, a read/write level of 0 (write) drives the port A input word onto the port B output with port B valid high, and port A valid low, from that edge on.
- R2: Under the same conditions, a read/write level of 1 (read) drives the port B input word onto the port A output with port A valid high, and port B valid low, from that edge on.
- R3: The direction is taken fresh at every rising edge from port A's read/write input while reset is low, so alternating levels on consecutive edges alternate the transfer direction.
- R4: With reset low, at an edge where port A enable or request is low, no transfer occurs: both valid outputs are 0 and both data outputs are 0 after that edge.
- R5: Port B's enable, request and read/write inputs have no effect on any output, whether port A is idle or transferring.
- R6: At every rising edge with reset high, both data outputs become 0 and both valid outputs become 0, whatever port A's controls are.
- R7: Reset-done is 0 after every rising edge with reset low. It becomes 1 at the first rising edge with reset high, provided a rising and a falling clock edge were both seen while reset was low.
- R8: A reset low period that spans only a rising clock edge and no falling edge leaves reset-done at 0 after release, and it stays 0 until a later reset low period qualifies.
- R9: Once reset-done is 1, it stays 1 for as long as reset stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; the bypass works while it is low |
| portAEn | input | 1 | Port A enable |
| portAReq | input | 1 | Port A request |
| portARdNWr | input | 1 | Port A direction: 1 = B to A, 0 = A to B |
| portAIn | input | 36 | Port A input word |
| portAOut | output | 36 | Registered word delivered to port A |
| portAOutValid | output | 1 | Port A output holds a transferred word |
| portBEn | input | 1 | Port B enable (no effect during bypass) |
| portBReq | input | 1 | Port B request (no effect during bypass) |
| portBRdNWr | input | 1 | Port B direction (no effect during bypass) |
| portBIn | input | 36 | Port B input word |
| portBOut | output | 36 | Registered word delivered to port B |
| portBOutValid | output | 1 | Port B output holds a transferred word |
| resetDone | output | 1 | Reset has been qualified and released |

## Verification
The bench flips port A's direction on back-to-back edges. A design that latched the direction once per reset would route the second word to the wrong side. It drives port B's controls both while port A is idle and while port A writes, which exposes any path that lets the slave launch a transfer or flip the direction. It releases reset while port A still requests, to catch outputs that keep passing data after release. It also issues a reset pulse that covers a rising edge but no falling edge; a qualifier that counted either edge alone would raise reset-done there.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  typedef struct packed {
    logic latchToB;   // capture port A word for port B
    logic latchToA;   // capture port B word for port A
  } rbx_strobe_t;
endpackage

// File: rtl/rbx_ctrl.sv
module rbx_ctrl
  import rbx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        aEn,
  input  logic        aReq,
  input  logic        aRdNWr,
  output rbx_strobe_t strobe,
  output logic        resetDone
);
  logic roseLow;
  logic fellLow;
  logic aGo;

  assign aGo = !rstN && aEn && aReq;

  always_comb begin
    strobe.latchToB = aGo && !aRdNWr;
    strobe.latchToA = aGo && aRdNWr;
  end

  // edge seen on the rising side while reset is low
  always_ff @(posedge clk) begin
    if (!rstN)          roseLow <= 1'b1;
    else if (resetDone) roseLow <= 1'b0;
  end

  // edge seen on the falling side while reset is low
  always_ff @(negedge clk) begin
    if (!rstN)          fellLow <= 1'b1;
    else if (resetDone) fellLow <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   resetDone <= 1'b0;
    else if (roseLow && fellLow) resetDone <= 1'b1;
  end

  AST_DONE_LOW_IN_RESET: assert property (@(posedge clk)
    (!rstN) |=> !resetDone); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    resetDone |=> resetDone); // R9
endmodule

// File: rtl/rbx_dp.sv
module rbx_dp
  import rbx_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  rbx_strobe_t       strobe,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aVal,
  output logic [DATA_W-1:0] bOut,
  output logic              bVal
);
  localparam logic [DATA_W-1:0] IDLE_WORD = '0;

  always_ff @(posedge clk) begin
    bVal <= strobe.latchToB;
    bOut <= strobe.latchToB ? aIn : IDLE_WORD;
    aVal <= strobe.latchToA;
    aOut <= strobe.latchToA ? bIn : IDLE_WORD;
  end

  AST_B_CAPTURE: assert property (@(posedge clk)
    strobe.latchToB |=> (bVal && !aVal && bOut == $past(aIn))); // R1

  AST_A_CAPTURE: assert property (@(posedge clk)
    strobe.latchToA |=> (aVal && !bVal && aOut == $past(bIn))); // R2

  AST_NO_STROBE_IDLE: assert property (@(posedge clk)
    !(strobe.latchToA || strobe.latchToB) |=> (!aVal && !bVal)); // R4
endmodule

// File: rtl/rbx_top.sv
module rbx_top
  import rbx_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portAEn,
  input  logic              portAReq,
  input  logic              portARdNWr,
  input  logic [DATA_W-1:0] portAIn,
  output logic [DATA_W-1:0] portAOut,
  output logic              portAOutValid,
  input  logic              portBEn,
  input  logic              portBReq,
  input  logic              portBRdNWr,
  input  logic [DATA_W-1:0] portBIn,
  output logic [DATA_W-1:0] portBOut,
  output logic              portBOutValid,
  output logic              resetDone
);
  rbx_strobe_t strobe;

  rbx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .aEn(portAEn), .aReq(portAReq),
    .aRdNWr(portARdNWr), .strobe(strobe), .resetDone(resetDone)
  );

  rbx_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .strobe(strobe), .aIn(portAIn), .bIn(portBIn),
    .aOut(portAOut), .aVal(portAOutValid), .bOut(portBOut), .bVal(portBOutValid)
  );

  AST_DIR_FOLLOWS_A: assert property (@(posedge clk)
    (!rstN && portAEn && portAReq) |=> (portAOutValid == $past(portARdNWr)
      && portBOutValid == !$past(portARdNWr))); // R3

  AST_SLAVE_IGNORED: assert property (@(posedge clk)
    (!rstN && portBEn && portBReq && !(portAEn && portAReq))
      |=> (!portAOutValid && !portBOutValid)); // R5

  AST_SLAVE_NO_DIR: assert property (@(posedge clk)
    (!rstN && portBEn && portBReq && portBRdNWr && portAEn && portAReq && !portARdNWr)
      |=> (portBOutValid && !portAOutValid)); // R5

  AST_IDLE_AFTER_RELEASE: assert property (@(posedge clk)
    rstN |=> (!portAOutValid && !portBOutValid && portAOut == '0 && portBOut == '0)); // R6
endmodule

// File: tb/rbx_top_tb.sv
module rbx_top_tb_top;
  localparam int W = 36;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aEn = 1'b0, aReq = 1'b0, aRd = 1'b0, bEn = 1'b0, bReq = 1'b0, bRd = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, bOut;
  logic aV, bV, done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  bit doneAllowed = 0;   // bench view: reset qualified before release
  string curReq = "R4";

  always #10 clk = ~clk;   // 50 MHz

  rbx_top #(.DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .portAEn(aEn), .portAReq(aReq), .portARdNWr(aRd),
    .portAIn(aIn), .portAOut(aOut), .portAOutValid(aV), .portBEn(bEn),
    .portBReq(bReq), .portBRdNWr(bRd), .portBIn(bIn), .portBOut(bOut),
    .portBOutValid(bV), .resetDone(done)
  );

  task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  // One rising edge: model from the inputs seen at the edge, compare 2 ns later.
  task automatic edgeCheck();
    logic [W-1:0] eA, eB;
    logic eAV, eBV, eD;
    @(posedge clk);
    eA = '0; eB = '0; eAV = 0; eBV = 0;
    if (!rstN && aEn && aReq) begin
      if (aRd) begin eA = bIn; eAV = 1; end
      else     begin eB = aIn; eBV = 1; end
    end
    if (!rstN) eD = 0;
    else       eD = doneAllowed;
    #2;
    chk("portAOut", aOut, eA);
    chk("portAOutValid", W'(aV), W'(eAV));
    chk("portBOut", bOut, eB);
    chk("portBOutValid", W'(bV), W'(eBV));
    chk("resetDone", W'(done), W'(eD));
  endtask

  task automatic cyc(input string req, input logic en, input logic rq, input logic rd,
                     input logic [W-1:0] a, input logic [W-1:0] b);
    curReq = req; aEn = en; aReq = rq; aRd = rd; aIn = a; bIn = b;
    edgeCheck();
  endtask

  initial begin
    #20000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // Reset low from time zero: idle edges
    cyc("R4", 0, 0, 0, 36'h1, 36'h2);
    cyc("R7", 0, 0, 0, 36'h3, 36'h4);
    // Writes A -> B
    cyc("R1", 1, 1, 0, 36'hABCDE1234, 36'h111111111);
    cyc("R1", 1, 1, 0, 36'hFFFFFFFFF, 36'h0);
    cyc("R1", 1, 1, 0, 36'h800000001, 36'h5A5A5A5A5);
    // Reads B -> A
    cyc("R2", 1, 1, 1, 36'h0, 36'h123456789);
    cyc("R2", 1, 1, 1, 36'h777777777, 36'hFFFFFFFFF);
    cyc("R2", 1, 1, 1, 36'hC3C3C3C3C, 36'h000000001);
    // Alternating direction on consecutive edges
    for (int i = 0; i < 6; i++)
      cyc("R3", 1, 1, i[0], 36'(64'h100000000 + i), 36'(64'h2000000 + 3 * i));
    // Enable or request missing
    cyc("R4", 1, 0, 0, 36'hDEADBEEF0, 36'h1);
    cyc("R4", 0, 1, 1, 36'h1, 36'hDEADBEEF0);
    // Port B activity with port A idle, then during an A write
    bEn = 1; bReq = 1;
    bRd = 0; cyc("R5", 0, 0, 0, 36'h9, 36'hA);
    bRd = 1; cyc("R5", 0, 1, 0, 36'hB, 36'hC);
    bRd = 1; cyc("R5", 1, 1, 0, 36'h13579BDF0, 36'hF);
    bRd = 0; cyc("R5", 1, 1, 1, 36'h1, 36'h2468ACE01);
    bEn = 0; bReq = 0; bRd = 0;
    // Release with A still requesting: outputs idle, reset-done rises
    rstN = 1; doneAllowed = 1;
    cyc("R6", 1, 1, 0, 36'hAAAAAAAAA, 36'h555555555);
    cyc("R7", 1, 1, 1, 36'h1, 36'h2);
    for (int i = 0; i < 4; i++)
      cyc("R9", i[0], 1, i[1], 36'(i), 36'(i + 7));
    // Short reset pulse covering only a rising edge
    aEn = 0; aReq = 0;
    curReq = "R8";
    #10;           // now past the falling edge
    rstN = 0;
    edgeCheck();   // the one rising edge seen low
    rstN = 1; doneAllowed = 0;
    for (int i = 0; i < 4; i++) cyc("R8", 1, 1, 0, 36'h3, 36'h4);
    // Full reset qualifies again
    rstN = 0;
    cyc("R7", 0, 0, 0, 36'h0, 36'h0);
    cyc("R1", 1, 1, 0, 36'h0F0F0F0F0, 36'h0);
    rstN = 1; doneAllowed = 1;
    cyc("R7", 0, 0, 0, 36'h0, 36'h0);
    cyc("R9", 0, 0, 0, 36'h0, 36'h0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule